// File: doc/BRIEF.md
# Load-Multiple Word Sequencer

This block takes a single load-multiple or load-string request and expands it into a series of aligned 32-bit word reads. Each returned word goes to one register-file write. The first register written is the destination register named in the request. For a load-multiple, every register from there up to the top register is loaded. For a load-string, the byte count decides how many registers are loaded. Word addresses step by four from the effective address, one word per register.

Before any bus activity the request is screened. A misaligned effective address is refused, and so is a request made in little-endian mode. Either condition produces a one-cycle alignment-exception pulse, with no memory read and no register write. The base register needs no special handling. If it lies inside the loaded range, it is overwritten from its own slot like any other register, and the instruction completes normally. A done pulse marks completion, and a busy flag shows that new requests are being ignored.

Top module: `lmw_seq_top`

## Requirements
- R1: A load-multiple (`reqIsString`=0) with destination d writes registers d, d+1, … 31 in ascending order, one per cycle of accepted data. Register d+i receives the word read at `reqEa`+4·i, and every memory address issued has bits [1:0] equal to 0.
- R2: A load-string (`reqIsString`=1) with byte count n writes ceil(n/4) registers. It starts at d, steps upward, and wraps from 31 to 0. Register i receives the word at `reqEa`+4·i.
- R3: When n mod 4 is k≠0, the last string register holds the first k bytes of its word in its most significant bytes (bits 31:24 first), and the remaining low bytes are zero.
- R4: A request whose `reqEa`[1:0]≠0 produces exactly one `alignExc` pulse. It issues no `memReq`, makes no `rfWe` and raises no `done`. This applies to both load kinds.
- R5: A request with `reqLittleEnd`=1 is refused in the same way as in R4, whatever its address.
- R6: When the base register lies inside the loaded range, it receives the word at `reqEa`+4·(base−d), and the request ends with `done`, not `alignExc`.
- R7: `done` pulses for exactly one cycle, the cycle after the last `rfWe`, and never together with `alignExc`.
- R8: `busy` is high from the cycle after acceptance until the completing pulse. Requests presented while busy are ignored.
- R9: A string request with n=0 pulses `done` one cycle after acceptance, with no `memReq` and no `rfWe`.
- R10: After reset, `busy`, `memReq`, `rfWe`, `done` and `alignExc` are all low.
- R11: While `memReq` is high and `memReady` is low, `memReq` stays high and `memAddr` stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqEa | input | 32 | Effective address |
| reqRd | input | 5 | First destination register |
| reqIsString | input | 1 | 1 = string load, 0 = load-multiple |
| reqByteCnt | input | 7 | String byte count |
| reqLittleEnd | input | 1 | Little-endian mode flag |
| busy | output | 1 | Sequence in progress |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Word read address |
| memReady | input | 1 | Read data valid, completes the request |
| memData | input | 32 | Read data |
| rfWe | output | 1 | Register write enable |
| rfAddr | output | 5 | Register index |
| rfData | output | 32 | Register write data |
| done | output | 1 | Completion pulse |
| alignExc | output | 1 | Alignment exception pulse |

## Verification
The in-line assertions check the following on every cycle:
- issued addresses are word aligned;
- the read request and its address hold through memory stalls;
- register indices ascend between back-to-back writes;
- a refusal never coincides with a read or a write;
- the two completion pulses exclude each other, and `done` is preceded by a write or by an idle cycle.

Only the bench scenarios can show the data itself: which word lands in which register, the masking of a partial final string word, the wrap past register 31, the base register loaded from its own slot, and a request ignored while busy.

// File: rtl/lmw_seq_pkg.sv
package lmw_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_DRAIN,
    ST_FIN,
    ST_TRAP
  } seqStateT;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture request fields
    logic step;   // a word was accepted from memory
    logic last;   // accepted word is the final one
  } seqStrobeT;

endpackage

// File: rtl/lmw_seq_ctrl.sv
module lmw_seq_ctrl
  import lmw_seq_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int BCNT_W = 7,
  parameter int WCNT_W = REG_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqEaLow,
  input  logic [REG_W-1:0]  reqRd,
  input  logic              reqIsString,
  input  logic [BCNT_W-1:0] reqByteCnt,
  input  logic              reqLittleEnd,
  input  logic              memReady,
  output seqStrobeT         strobe,
  output logic              memReq,
  output logic              busy,
  output logic              done,
  output logic              alignExc
);

  localparam int NREG = 1 << REG_W;

  seqStateT          state, nextState;
  logic [WCNT_W-1:0] wordsLeft, nextLeft;
  logic [WCNT_W-1:0] wordsNeeded;
  logic [BCNT_W:0]   bytesRounded;
  logic              fault;

  always_comb begin
    bytesRounded = {1'b0, reqByteCnt} + (BCNT_W+1)'(3);
    if (reqIsString)
      wordsNeeded = WCNT_W'(bytesRounded >> 2);
    else
      wordsNeeded = WCNT_W'(NREG) - WCNT_W'(reqRd);
    fault = reqLittleEnd || (reqEaLow != 2'b00);
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextLeft  = wordsLeft;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          if (fault)
            nextState = ST_TRAP;
          else if (wordsNeeded == '0)
            nextState = ST_FIN;
          else begin
            nextState = ST_READ;
            nextLeft  = wordsNeeded;
          end
        end
      end
      ST_READ: begin
        if (memReady) begin
          strobe.step = 1'b1;
          if (wordsLeft == WCNT_W'(1)) begin
            strobe.last = 1'b1;
            nextState   = ST_DRAIN;
          end else begin
            nextLeft = wordsLeft - WCNT_W'(1);
          end
        end
      end
      ST_DRAIN: nextState = ST_FIN;
      ST_FIN:   nextState = ST_IDLE;
      ST_TRAP:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordsLeft <= '0;
    end else begin
      state     <= nextState;
      wordsLeft <= nextLeft;
    end
  end

  assign memReq   = (state == ST_READ);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign alignExc = (state == ST_TRAP);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

endmodule

// File: rtl/lmw_seq_datapath.sv
module lmw_seq_datapath
  import lmw_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int BCNT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [ADDR_W-1:0] reqEa,
  input  logic [REG_W-1:0]  reqRd,
  input  logic              reqIsString,
  input  logic [BCNT_W-1:0] reqByteCnt,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rfWe,
  output logic [REG_W-1:0]  rfAddr,
  output logic [DATA_W-1:0] rfData
);

  localparam int NBYTE = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [REG_W-1:0]  regIdxQ;
  logic [1:0]        tailQ;
  logic [DATA_W-1:0] tailMask;
  logic [DATA_W-1:0] wordOut;

  // Keep leading bytes (most significant first) of the final partial word
  always_comb begin
    tailMask = '0;
    for (int b = 0; b < NBYTE; b++) begin
      if (tailQ == 2'd0 || b < int'(tailQ))
        tailMask[DATA_W-1-8*b -: 8] = 8'hFF;
    end
    wordOut = strobe.last ? (memData & tailMask) : memData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      regIdxQ <= '0;
      tailQ   <= '0;
      rfWe    <= 1'b0;
      rfAddr  <= '0;
      rfData  <= '0;
    end else begin
      rfWe <= 1'b0;
      if (strobe.load) begin
        addrQ   <= reqEa;
        regIdxQ <= reqRd;
        tailQ   <= reqIsString ? reqByteCnt[1:0] : 2'd0;
      end else if (strobe.step) begin
        addrQ   <= addrQ + ADDR_W'(4);
        regIdxQ <= regIdxQ + REG_W'(1);
        rfWe    <= 1'b1;
        rfAddr  <= regIdxQ;
        rfData  <= wordOut;
      end
    end
  end

  assign memAddr = addrQ;

  AST_RF_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    rfWe && $past(rfWe) |-> rfAddr == REG_W'($past(rfAddr) + REG_W'(1))); // R1

endmodule

// File: rtl/lmw_seq_top.sv
module lmw_seq_top
  import lmw_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int BCNT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqEa,
  input  logic [REG_W-1:0]  reqRd,
  input  logic              reqIsString,
  input  logic [BCNT_W-1:0] reqByteCnt,
  input  logic              reqLittleEnd,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memData,
  output logic              rfWe,
  output logic [REG_W-1:0]  rfAddr,
  output logic [DATA_W-1:0] rfData,
  output logic              done,
  output logic              alignExc
);

  localparam int WCNT_W = REG_W + 1;

  seqStrobeT strobe;

  lmw_seq_ctrl #(
    .REG_W (REG_W),
    .BCNT_W(BCNT_W),
    .WCNT_W(WCNT_W)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqEaLow    (reqEa[1:0]),
    .reqRd       (reqRd),
    .reqIsString (reqIsString),
    .reqByteCnt  (reqByteCnt),
    .reqLittleEnd(reqLittleEnd),
    .memReady    (memReady),
    .strobe      (strobe),
    .memReq      (memReq),
    .busy        (busy),
    .done        (done),
    .alignExc    (alignExc)
  );

  lmw_seq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .REG_W (REG_W),
    .BCNT_W(BCNT_W)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqEa      (reqEa),
    .reqRd      (reqRd),
    .reqIsString(reqIsString),
    .reqByteCnt (reqByteCnt),
    .memData    (memData),
    .memAddr    (memAddr),
    .rfWe       (rfWe),
    .rfAddr     (rfAddr),
    .rfData     (rfData)
  );

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(memAddr)); // R11
  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    alignExc |-> !rfWe && !memReq); // R4
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, alignExc})); // R7
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(rfWe) || !$past(busy)); // R7

endmodule

// File: tb/tb_lmw_seq_top.sv
module tb_lmw_seq_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        isStr;
    logic        le;
    logic        slow;
    logic [31:0] ea;
    logic [4:0]  rd;
    logic [4:0]  ra;
    logic [6:0]  bc;
    logic        expFault;
  } vecT;

  localparam int NVEC = 11;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 32'h0000_0100, 5'd28, 5'd2,  7'd0,  1'b0}, // R1
    '{1'b0, 1'b0, 1'b1, 32'h0000_0200, 5'd29, 5'd30, 7'd0,  1'b0}, // R6 R11
    '{1'b0, 1'b0, 1'b0, 32'h0000_0102, 5'd30, 5'd1,  7'd0,  1'b1}, // R4
    '{1'b0, 1'b1, 1'b0, 32'h0000_0100, 5'd30, 5'd1,  7'd0,  1'b1}, // R5
    '{1'b1, 1'b0, 1'b0, 32'h0000_0300, 5'd5,  5'd1,  7'd10, 1'b0}, // R2 R3
    '{1'b1, 1'b0, 1'b1, 32'h0000_0400, 5'd30, 5'd0,  7'd13, 1'b0}, // R2 wrap R3
    '{1'b1, 1'b0, 1'b0, 32'h0000_0500, 5'd7,  5'd1,  7'd0,  1'b0}, // R9
    '{1'b1, 1'b1, 1'b0, 32'h0000_0600, 5'd7,  5'd1,  7'd8,  1'b1}, // R5
    '{1'b1, 1'b0, 1'b1, 32'h0000_0404, 5'd3,  5'd4,  7'd8,  1'b0}, // R6 string
    '{1'b0, 1'b0, 1'b0, 32'h0000_0800, 5'd31, 5'd2,  7'd0,  1'b0}, // R1 single
    '{1'b0, 1'b0, 1'b0, 32'h0000_1000, 5'd0,  5'd15, 7'd0,  1'b0}  // R1 R6 full
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqEa = '0;
  logic [4:0]  reqRd = '0;
  logic        reqIsString = 1'b0;
  logic [6:0]  reqByteCnt = '0;
  logic        reqLittleEnd = 1'b0;
  logic        busy, memReq, memReady, rfWe, done, alignExc;
  logic [31:0] memAddr, memData, rfData;
  logic [4:0]  rfAddr;

  logic        slowMode = 1'b0;
  logic        phase = 1'b0;

  int nCompared = 0;
  int nMismatch = 0;

  // monitor state
  int          nW, doneCnt, excCnt, ncyc, lastWeCyc, doneCyc;
  logic        memSeen;
  logic [4:0]  wA [64];
  logic [31:0] wD [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign memData  = memWord(memAddr);
  assign memReady = memReq && (!slowMode || phase);

  lmw_seq_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEa(reqEa), .reqRd(reqRd),
    .reqIsString(reqIsString), .reqByteCnt(reqByteCnt), .reqLittleEnd(reqLittleEnd),
    .busy(busy), .memReq(memReq), .memAddr(memAddr), .memReady(memReady),
    .memData(memData), .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData),
    .done(done), .alignExc(alignExc)
  );

  always @(negedge clk) begin
    phase <= ~phase;
    if (rfWe) begin
      if (nW < 64) begin
        wA[nW] = rfAddr;
        wD[nW] = rfData;
      end
      nW++;
      lastWeCyc = ncyc;
    end
    if (memReq) memSeen = 1'b1;
    if (done) begin doneCnt++; doneCyc = ncyc; end
    if (alignExc) excCnt++;
    ncyc++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(posedge clk);
    nW = 0; doneCnt = 0; excCnt = 0; memSeen = 1'b0;
    lastWeCyc = -10; doneCyc = -1;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      if (doneCnt != 0 || excCnt != 0) break;
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic issue(input vecT v);
    @(negedge clk);
    slowMode     = v.slow;
    reqEa        = v.ea;
    reqRd        = v.rd;
    reqIsString  = v.isStr;
    reqByteCnt   = v.bc;
    reqLittleEnd = v.le;
    reqValid     = 1'b1;
    @(negedge clk);
    reqValid     = 1'b0;
  endtask

  task automatic runVec(input int idx);
    vecT         v;
    int          expN, tail, slot;
    logic [31:0] expW, msk;
    v = VECS[idx];
    clearMon();
    issue(v);
    waitEnd();
    if (v.expFault) begin
      chk(excCnt == 1, v.le ? "R5 exc pulse" : "R4 exc pulse", excCnt, 1);
      chk(nW == 0, v.le ? "R5 no write" : "R4 no write", nW, 0);
      chk(!memSeen, v.le ? "R5 no read" : "R4 no read", memSeen, 0);
      chk(doneCnt == 0, "R4 no done", doneCnt, 0);
    end else begin
      expN = v.isStr ? (int'(v.bc) + 3) / 4 : 32 - int'(v.rd);
      tail = v.isStr ? int'(v.bc) % 4 : 0;
      chk(excCnt == 0, "R6 no exception", excCnt, 0);
      chk(doneCnt == 1, "R7 single done", doneCnt, 1);
      chk(nW == expN, v.isStr ? "R2 write count" : "R1 write count", nW, expN);
      if (expN == 0) begin
        chk(!memSeen, "R9 no read", memSeen, 0);
      end else begin
        chk(doneCyc == lastWeCyc + 1, "R7 done timing", doneCyc, lastWeCyc + 1);
        for (int i = 0; i < expN && i < nW; i++) begin
          expW = memWord(v.ea + 32'(4 * i));
          if (i == expN - 1 && tail != 0) begin
            msk  = ~(32'hFFFF_FFFF >> (8 * tail));
            expW = expW & msk;
            chk(wD[i] == expW, "R3 partial word", wD[i], expW);
          end else begin
            chk(wD[i] == expW, v.slow ? "R11 data under stall" : "R1 data", wD[i], expW);
          end
          chk(wA[i] == 5'(int'(v.rd) + i), v.isStr ? "R2 reg order" : "R1 reg order",
              32'(wA[i]), 32'(5'(int'(v.rd) + i)));
        end
        slot = int'(5'(v.ra - v.rd));
        if (slot < expN && slot < nW)
          chk(wD[slot] == memWord(v.ea + 32'(4 * slot)), "R6 base reg slot",
              wD[slot], memWord(v.ea + 32'(4 * slot)));
      end
    end
  endtask

  initial begin
    vecT bv;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, memReq, rfWe, done, alignExc} == 5'b0, "R10 reset outputs",
        32'({busy, memReq, rfWe, done, alignExc}), 0);

    for (int k = 0; k < NVEC; k++) runVec(k);

    // R9 exact timing: done the cycle after acceptance
    clearMon();
    @(negedge clk);
    reqIsString = 1'b1; reqByteCnt = 7'd0; reqLittleEnd = 1'b0; reqEa = 32'h40;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(done == 1'b1, "R9 done next cycle", 32'(done), 1);
    waitEnd();
    chk(nW == 0, "R9 no write", nW, 0);

    // R8: requests while busy are ignored
    clearMon();
    bv = '{1'b0, 1'b0, 1'b1, 32'h0000_0700, 5'd28, 5'd1, 7'd0, 1'b0};
    issue(bv);
    chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 1);
    reqLittleEnd = 1'b1; reqRd = 5'd0; reqValid = 1'b1;
    repeat (3) @(negedge clk);
    reqValid = 1'b0; reqLittleEnd = 1'b0;
    waitEnd();
    repeat (6) @(posedge clk);
    chk(nW == 4, "R8 write count unchanged", nW, 4);
    chk(excCnt == 0, "R8 no exception from ignored request", excCnt, 0);
    chk(doneCnt == 1, "R8 single completion", doneCnt, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R8 busy clears", 32'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nCompared++;
    nMismatch++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule